// File: doc/BRIEF.md
# Partial-Line Burst-Fill Instruction Cache

This block is a direct-mapped instruction cache that tracks validity per 32-bit word rather than per line. A fetch is a hit only when the stored tag of the indexed line matches and the valid bit of the addressed word is set. A partly filled line can therefore hit on some words and miss on others. On a miss the cache issues one burst read that starts at the missed word and runs upward to the last word of the line. It never wraps back to the lower words. Every word in that range is fetched and written again, even if it was already valid.

The core fetch port is a request/response handshake. The core raises `fetch_valid` with `fetch_addr` and keeps both steady until `fetch_ready` is high; `fetch_rdata` is valid in that same cycle. A hit completes in the cycle it is presented. On a miss the core waits until the missed word arrives from memory. That word is passed straight through to `fetch_rdata` in the cycle it arrives, and the rest of the burst is written in the background. While that happens, hits from the core are still served, and any new miss waits until the burst ends. On the memory side, `mem_req_valid` with `mem_addr` is held until `mem_req_ready`. Read beats (`mem_rvalid`, `mem_rdata`, `mem_rlast`) have no back-pressure and the cache accepts one beat per cycle. A pulse on `fill_abort` during a fill stops it at once.

Parameters are the byte address width, the words per line (4 or 8, that is 16- or 32-byte lines), the number of sets and the data width.

Top module: `icache_burstfill`

## Requirements
- R1: A fetch whose tag matches the stored tag of its set and whose word valid bit is set raises `fetch_ready` in the same cycle with the stored word on `fetch_rdata`.
- R2: A fetch miss while the cache is idle raises `mem_req_valid` on the next cycle, with `mem_addr` equal to the fetch address with bits [1:0] cleared. The address is held unchanged until `mem_req_ready` is sampled high.
- R3: The burst writes words from the missed word offset up to offset LINE_WORDS-1, then ends. Words below the missed offset keep their earlier state, so such a word that was invalid still misses afterwards.
- R4: Words in the burst range that were already valid are written again with the data memory returns in this burst.
- R5: On a miss, `fetch_ready` stays low until the first non-aborted beat of the burst. In that beat's cycle `fetch_ready` is high and `fetch_rdata` equals `mem_rdata`.
- R6: After the missed word has been returned, hits are served while the rest of the burst is still being written.
- R7: A miss whose tag differs from the stored tag clears every valid bit of that line before the burst. Words of the new tag outside the burst range miss, and the old tag misses on every word.
- R8: `fill_abort` during a fill returns the cache to idle on the next cycle with no memory request raised. The words already received stay valid and the rest stay invalid. A beat arriving in the same cycle as the abort, or after it, is not written.
- R9: After reset every word of every line is invalid, and `fetch_ready` and `mem_req_valid` are low.
- R10: `fetch_ready` is never high while `fetch_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Core fetch request, held until accepted |
| fetch_addr | input | ADDR_W | Byte address of the fetch |
| fetch_ready | output | 1 | Fetch completes this cycle |
| fetch_rdata | output | DATA_W | Instruction word, valid with fetch_ready |
| mem_req_valid | output | 1 | Burst read request |
| mem_req_ready | input | 1 | Memory accepts the burst request |
| mem_addr | output | ADDR_W | Byte address of the first burst word |
| mem_rvalid | input | 1 | Read beat present |
| mem_rdata | input | DATA_W | Read beat data |
| mem_rlast | input | 1 | Final beat of the burst |
| fill_abort | input | 1 | Stop the fill in progress |

## Verification
The hardest states to reach from the ports are a line left half valid by an abort at a chosen beat, and a late beat after such an abort. The bench's memory model arms an abort at a chosen beat count, sometimes together with a beat and sometimes followed by a stray beat, and then checks which words of that line hit. Re-fetch of already-valid words is only visible if memory contents change between bursts. The memory data therefore carries an epoch number that the bench bumps, so a re-fetched word must come back with the new value.

// File: rtl/icfill_pkg.sv
package icfill_pkg;
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_FILL = 2'd2
  } fill_st_e;
endpackage

// File: rtl/icf_store.sv
module icf_store #(
  parameter  int ADDR_W     = 16,
  parameter  int LINE_WORDS = 8,
  parameter  int SETS       = 16,
  parameter  int DATA_W     = 32,
  localparam int OFF_W      = $clog2(LINE_WORDS),
  localparam int IDX_W      = $clog2(SETS),
  localparam int TAG_W      = ADDR_W - 2 - OFF_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [OFF_W-1:0]  rd_off,
  input  logic [TAG_W-1:0]  rd_tag,
  output logic              tag_match,
  output logic              word_hit,
  output logic [DATA_W-1:0] rd_data,
  input  logic              line_clr,
  input  logic [IDX_W-1:0]  line_idx,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data
);
  logic [TAG_W-1:0]      tags  [SETS];
  logic [DATA_W-1:0]     words [SETS*LINE_WORDS];
  logic [LINE_WORDS-1:0] vld_w [SETS];

  // one valid vector per set, cleared on tag change, set per written word
  for (genvar s = 0; s < SETS; s++) begin : g_vld
    logic [LINE_WORDS-1:0] v_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q <= '0;
      end else if (line_clr && line_idx == IDX_W'(s)) begin
        v_q <= '0;
      end else if (wr_en && line_idx == IDX_W'(s)) begin
        v_q[wr_off] <= 1'b1;
      end
    end
    assign vld_w[s] = v_q;
  end

  always_ff @(posedge clk) begin
    if (line_clr) tags[line_idx] <= line_tag;
    if (wr_en)    words[{line_idx, wr_off}] <= wr_data;
  end

  always_comb begin
    tag_match = (tags[rd_idx] == rd_tag);
    word_hit  = tag_match && vld_w[rd_idx][rd_off];
    rd_data   = words[{rd_idx, rd_off}];
  end
endmodule

// File: rtl/icf_fill_ctrl.sv
module icf_fill_ctrl
  import icfill_pkg::*;
#(
  parameter  int ADDR_W     = 16,
  parameter  int LINE_WORDS = 8,
  parameter  int SETS       = 16,
  localparam int OFF_W      = $clog2(LINE_WORDS),
  localparam int IDX_W      = $clog2(SETS),
  localparam int TAG_W      = ADDR_W - 2 - OFF_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic              word_hit,
  input  logic              tag_match,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic              mem_req_ready,
  input  logic              mem_rvalid,
  input  logic              mem_rlast,
  input  logic              abort_i,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              line_clr,
  output logic [IDX_W-1:0]  line_idx,
  output logic [TAG_W-1:0]  line_tag,
  output logic              wr_en,
  output logic [OFF_W-1:0]  wr_off,
  output logic              crit_fwd,
  output logic              filling
);
  localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(LINE_WORDS - 1);

  fill_st_e         st_q, st_d;
  logic [IDX_W-1:0] idx_q;
  logic [TAG_W-1:0] tag_q;
  logic [OFF_W-1:0] off_q;
  logic             crit_q;
  logic             miss;

  assign miss = fetch_valid && !word_hit;

  always_comb begin
    st_d     = st_q;
    line_clr = 1'b0;
    wr_en    = 1'b0;
    crit_fwd = 1'b0;
    unique case (st_q)
      FS_IDLE: if (miss) begin
        st_d     = FS_REQ;
        line_clr = !tag_match;
      end
      FS_REQ: if (mem_req_ready) st_d = FS_FILL;
      FS_FILL: begin
        if (abort_i) begin
          st_d = FS_IDLE;
        end else if (mem_rvalid) begin
          wr_en    = 1'b1;
          crit_fwd = crit_q;
          if (mem_rlast || off_q == OFF_LAST) st_d = FS_IDLE;
        end
      end
      default: st_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= FS_IDLE;
      idx_q  <= '0;
      tag_q  <= '0;
      off_q  <= '0;
      crit_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == FS_IDLE && miss) begin
        idx_q  <= req_idx;
        tag_q  <= req_tag;
        off_q  <= req_off;
        crit_q <= 1'b1;
      end else if (wr_en) begin
        off_q  <= off_q + 1'b1;
        crit_q <= 1'b0;
      end
    end
  end

  assign mem_req_valid = (st_q == FS_REQ);
  assign mem_addr      = {tag_q, idx_q, off_q, 2'b00};
  assign line_idx      = (st_q == FS_IDLE) ? req_idx : idx_q;
  assign line_tag      = (st_q == FS_IDLE) ? req_tag : tag_q;
  assign wr_off        = off_q;
  assign filling       = (st_q == FS_FILL);
endmodule

// File: rtl/icache_burstfill.sv
module icache_burstfill #(
  parameter  int ADDR_W     = 16,
  parameter  int LINE_WORDS = 8,
  parameter  int SETS       = 16,
  parameter  int DATA_W     = 32,
  localparam int OFF_W      = $clog2(LINE_WORDS),
  localparam int IDX_W      = $clog2(SETS),
  localparam int TAG_W      = ADDR_W - 2 - OFF_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_ready,
  output logic [DATA_W-1:0] fetch_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_rlast,
  input  logic              fill_abort
);
  logic [OFF_W-1:0]  f_off;
  logic [IDX_W-1:0]  f_idx;
  logic [TAG_W-1:0]  f_tag;
  logic              tag_match, word_hit, line_clr, wr_en, crit_fwd, filling;
  logic [IDX_W-1:0]  line_idx;
  logic [TAG_W-1:0]  line_tag;
  logic [OFF_W-1:0]  wr_off;
  logic [DATA_W-1:0] rd_data;

  assign f_off = fetch_addr[OFF_W+1:2];
  assign f_idx = fetch_addr[OFF_W+IDX_W+1:OFF_W+2];
  assign f_tag = fetch_addr[ADDR_W-1:ADDR_W-TAG_W];

  icf_store #(
    .ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS), .SETS(SETS), .DATA_W(DATA_W)
  ) store_i (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(f_idx), .rd_off(f_off), .rd_tag(f_tag),
    .tag_match(tag_match), .word_hit(word_hit), .rd_data(rd_data),
    .line_clr(line_clr), .line_idx(line_idx), .line_tag(line_tag),
    .wr_en(wr_en), .wr_off(wr_off), .wr_data(mem_rdata)
  );

  icf_fill_ctrl #(
    .ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS), .SETS(SETS)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid(fetch_valid), .word_hit(word_hit), .tag_match(tag_match),
    .req_idx(f_idx), .req_off(f_off), .req_tag(f_tag),
    .mem_req_ready(mem_req_ready), .mem_rvalid(mem_rvalid), .mem_rlast(mem_rlast),
    .abort_i(fill_abort),
    .mem_req_valid(mem_req_valid), .mem_addr(mem_addr),
    .line_clr(line_clr), .line_idx(line_idx), .line_tag(line_tag),
    .wr_en(wr_en), .wr_off(wr_off), .crit_fwd(crit_fwd), .filling(filling)
  );

  // missed word is passed through in the cycle it arrives
  assign fetch_ready = (fetch_valid && word_hit) || crit_fwd;
  assign fetch_rdata = crit_fwd ? mem_rdata : rd_data;
endmodule

// File: rtl/icache_burstfill_chk.sv
module icache_burstfill_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_valid,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              fetch_ready,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rvalid,
  input logic              mem_rlast,
  input logic              fill_abort,
  input logic              filling
);
  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ready |-> fetch_valid); // R10

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr)); // R2

  AST_REQ_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) |-> mem_addr == {fetch_addr[ADDR_W-1:2], 2'b00}); // R2

  AST_FILL_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> filling); // R2

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    filling && fill_abort |=> !filling && !mem_req_valid); // R8

  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    filling && mem_rvalid && mem_rlast && !fill_abort |=> !filling); // R3
endmodule

bind icache_burstfill icache_burstfill_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
  .fetch_ready(fetch_ready), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rlast(mem_rlast),
  .fill_abort(fill_abort), .filling(filling)
);

// File: tb/icache_burstfill_tb_top.sv
module icache_burstfill_tb_top;
  localparam int ADDR_W = 16, LW = 8, SETS = 16, DATA_W = 32;
  localparam int OFF_W = $clog2(LW), IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - 2 - OFF_W - IDX_W;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n, fetch_valid, fetch_ready, mem_req_valid, mem_req_ready;
  logic [ADDR_W-1:0] fetch_addr, mem_addr;
  logic [DATA_W-1:0] fetch_rdata, mem_rdata;
  logic              mem_rvalid, mem_rlast, fill_abort;

  icache_burstfill #(.ADDR_W(ADDR_W), .LINE_WORDS(LW), .SETS(SETS), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .fetch_ready(fetch_ready), .fetch_rdata(fetch_rdata), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .mem_rlast(mem_rlast), .fill_abort(fill_abort)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;

  // expected cache contents, derived from the requirements
  logic [DATA_W-1:0] mdat [SETS][LW];
  bit                mvld [SETS][LW];
  logic [TAG_W-1:0]  mtag [SETS];
  bit                mtag_ok [SETS];

  // memory model state
  int                m_state = 0, m_beats = 0, m_ep = 0, epoch = 0, abort_at = -1;
  bit                late_en = 0, m_first = 0, beat_crit = 0, acc_pend = 0, pc_pend = 0;
  logic [ADDR_W-3:0] m_wa;
  logic [ADDR_W-1:0] acc_addr, core_addr;
  int                pc_set, pc_off;
  logic [DATA_W-1:0] pc_data;

  function automatic logic [DATA_W-1:0] memfn(input logic [ADDR_W-3:0] wa, input int ep);
    return (32'(wa) * 32'h0100_0193) ^ (32'(ep) * 32'h9E37_79B9) ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [ADDR_W-1:0] mk(input int t, input int s, input int o);
    return {TAG_W'(t), IDX_W'(s), OFF_W'(o), 2'b00};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog expired act=%0d exp<=150000", cyc);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  // memory responder: drives 1 ns after the edge, samples 3 ns after
  always begin : mem_p
    int s;
    logic [TAG_W-1:0] t;
    @(posedge clk);
    #1;
    if (!rst_n) begin
      mem_req_ready = 0; mem_rvalid = 0; mem_rdata = 0; mem_rlast = 0; fill_abort = 0;
      m_state = 0; acc_pend = 0; pc_pend = 0; beat_crit = 0;
    end else begin
      if (pc_pend) begin
        mdat[pc_set][pc_off] = pc_data;
        mvld[pc_set][pc_off] = 1;
        pc_pend = 0;
      end
      if (acc_pend) begin
        acc_pend = 0;
        s = int'(acc_addr[OFF_W+IDX_W+1:OFF_W+2]);
        t = acc_addr[ADDR_W-1:ADDR_W-TAG_W];
        if (!mtag_ok[s] || mtag[s] != t) begin
          for (int w = 0; w < LW; w++) mvld[s][w] = 0;
          mtag[s] = t;
          mtag_ok[s] = 1;
        end
        m_wa = acc_addr[ADDR_W-1:2]; m_ep = epoch; m_beats = 0; m_first = 1; m_state = 1;
      end
      mem_rvalid = 0; mem_rlast = 0; fill_abort = 0; beat_crit = 0; mem_req_ready = 0;
      case (m_state)
        0: mem_req_ready = ($urandom % 3) != 0;
        1: begin
          if (abort_at == m_beats) begin
            fill_abort = 1;
            abort_at = -1;
            if ($urandom % 2 == 1) begin
              mem_rvalid = 1;               // R8: beat alongside abort must be dropped
              mem_rdata = memfn(m_wa, m_ep);
            end
            m_state = late_en ? 2 : 0;
          end else if ($urandom % 3 != 0) begin
            mem_rvalid = 1;
            mem_rdata = memfn(m_wa, m_ep);
            beat_crit = m_first;
            m_first = 0;
            mem_rlast = (m_wa[OFF_W-1:0] == OFF_W'(LW - 1));
            pc_pend = 1;
            pc_set = int'(m_wa[OFF_W+IDX_W-1:OFF_W]);
            pc_off = int'(m_wa[OFF_W-1:0]);
            pc_data = mem_rdata;
            m_beats++;
            if (mem_rlast) m_state = 0;
            else m_wa = m_wa + 1'b1;
          end
        end
        default: begin
          mem_rvalid = 1;                   // R8: late beat after abort
          mem_rdata = 32'hBAD0_0000 ^ $urandom;
          m_state = 0;
        end
      endcase
      #2;
      if (mem_req_valid && mem_req_ready) begin
        acc_pend = 1;
        acc_addr = mem_addr;
        chk(mem_addr == {core_addr[ADDR_W-1:2], 2'b00}, "R2", "burst start address",
            32'(mem_addr), 32'({core_addr[ADDR_W-1:2], 2'b00}));
      end
    end
  end

  task automatic do_fetch(input logic [ADDR_W-1:0] a, input string req_in);
    int s, o, n;
    logic [TAG_W-1:0]  t;
    logic [DATA_W-1:0] ed;
    bit done, eh, er;
    string req;
    done = 0; n = 0;
    @(posedge clk);
    #1;
    fetch_valid = 1; fetch_addr = a; core_addr = a;
    s = int'(a[OFF_W+IDX_W+1:OFF_W+2]);
    o = int'(a[OFF_W+1:2]);
    t = a[ADDR_W-1:ADDR_W-TAG_W];
    while (!done) begin
      #2;
      eh = mtag_ok[s] && mtag[s] == t && mvld[s][o];
      req = (req_in != "") ? req_in : (eh ? "R1" : "R5");
      er = 0; ed = '0;
      if (eh) begin
        er = 1; ed = mdat[s][o];
      end else if (mem_rvalid && !fill_abort && beat_crit) begin
        er = 1; ed = memfn(a[ADDR_W-1:2], m_ep);
      end
      if (er) begin
        chk(fetch_ready === 1'b1 && fetch_rdata === ed, req,
            $sformatf("fetch %h data", a), fetch_ready ? fetch_rdata : 32'hxxxx_xxxx, ed);
        done = 1;
      end else begin
        chk(fetch_ready === 1'b0, req, $sformatf("stall %h ready", a), 32'(fetch_ready), 0);
      end
      n++;
      if (!done && n > 300) begin
        chk(0, req, "fetch timeout", 32'(n), 300);
        done = 1;
      end
      if (!done) begin
        @(posedge clk);
        #1;
      end
    end
  endtask

  task automatic idle_chk(input logic [ADDR_W-1:0] a);
    @(posedge clk);
    #1;
    fetch_valid = 0; fetch_addr = a;
    #2;
    chk(fetch_ready === 1'b0, "R10", "ready without valid", 32'(fetch_ready), 0);
  endtask

  task automatic wait_mem_idle(input logic [ADDR_W-1:0] a);
    idle_chk(a);
    while (m_state != 0 || acc_pend || mem_req_valid) idle_chk(a);
  endtask

  initial begin
    void'($urandom(32'd7321));
    fetch_valid = 0; fetch_addr = '0; core_addr = '0; rst_n = 0;
    for (int s = 0; s < SETS; s++) begin
      mtag_ok[s] = 0; mtag[s] = '0;
      for (int w = 0; w < LW; w++) begin mvld[s][w] = 0; mdat[s][w] = '0; end
    end
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    #2;
    chk(fetch_ready === 1'b0 && mem_req_valid === 1'b0, "R9", "outputs after reset",
        32'({fetch_ready, mem_req_valid}), 0);

    // R9: first access after reset misses; R5 critical word; R6 hits during burst
    do_fetch(mk(1, 2, 3), "R9");
    do_fetch(mk(1, 2, 5), "R6");
    do_fetch(mk(1, 2, 7), "R6");
    wait_mem_idle(mk(1, 2, 3));
    // R3: no wrap, word 1 still invalid; R4: refetch brings new data
    epoch = 1;
    do_fetch(mk(1, 2, 1), "R3");
    do_fetch(mk(1, 2, 4), "R4");
    wait_mem_idle(mk(1, 2, 4));
    do_fetch(mk(1, 2, 4), "R4");
    do_fetch(mk(1, 2, 0), "R3");
    wait_mem_idle(mk(1, 2, 0));
    do_fetch(mk(1, 2, 6), "R1");
    // R8: abort after two beats, late beat follows
    abort_at = 2; late_en = 1;
    do_fetch(mk(3, 5, 2), "R8");
    wait_mem_idle(mk(3, 5, 2));
    do_fetch(mk(3, 5, 3), "R8");
    do_fetch(mk(3, 5, 4), "R8");
    wait_mem_idle(mk(3, 5, 4));
    // R8: abort before the missed word arrives, core keeps waiting
    abort_at = 0; late_en = 0;
    do_fetch(mk(2, 6, 6), "R8");
    wait_mem_idle(mk(2, 6, 6));
    // R7: tag change clears the line
    do_fetch(mk(4, 2, 5), "R7");
    wait_mem_idle(mk(4, 2, 5));
    do_fetch(mk(4, 2, 1), "R7");
    wait_mem_idle(mk(4, 2, 1));
    do_fetch(mk(1, 2, 0), "R7");
    idle_chk(mk(1, 2, 0));

    for (int i = 0; i < 400; i++) begin
      if ($urandom % 20 == 0) epoch++;
      if (abort_at < 0 && $urandom % 6 == 0) begin
        abort_at = int'($urandom % 4);
        late_en = $urandom % 2 == 1;
      end
      if ($urandom % 5 == 0) idle_chk(mk(int'($urandom % 4), int'($urandom % 4), int'($urandom % LW)));
      do_fetch(mk(int'($urandom % 4), int'($urandom % 4), int'($urandom % LW)), "");
    end
    abort_at = -1;
    wait_mem_idle('0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule